// File: doc/BRIEF.md
# Page Write Buffer and Program Controller

This block sits between the serial bus engine of a two-wire EEPROM slave and its 8 KB byte array. The bus engine hands it a starting byte address, then each received data byte with a strobe. It also signals the end of every acknowledge slot, the start of every bus bit slot, a detected STOP and an abort. The block gathers the bytes of one write command in a 32-byte row buffer. Each accepted byte is stored at the current in-row position, and the position then advances within the row, wrapping back to the row's first byte.

When a STOP arrives in the slot directly after an acknowledge, and at least one byte was stored, the block commits. It raises `busy`, copies the stored bytes into the array through a simple write port, one byte per clock, and keeps `busy` high for a fixed, parameterised program time. A STOP at any other moment, or an abort, throws the stored bytes away. While `busy` is high every input from the bus engine is disregarded. The array itself, including its all-ones contents at power-up, lives outside this block.

`PROG_CYCLES` gives the program time in clock cycles. The default of 500000 is 10 ms at 50 MHz. It must be at least one more than the row size.

Top module: `page_prog_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, `busy` and `mem_we` are 0.
- R2: `addr_load` sets the row to `addr_in[12:5]` and the in-row position to `addr_in[4:0]`, and empties the buffer. A later `byte_stb` with `wp_on` low stores `byte_in` at that position, to be written to array address {row, position}.
- R3: After each stored byte only the 5-bit in-row position increments, and it wraps from 31 to 0 within the same row. A byte stored at a position already filled replaces the earlier byte.
- R4: A commit happens only when `stop_det` is high and `ack_done` was the last of {`ack_done`, `bit_tick`, `byte_stb`, `addr_load`, `abort`, `stop_det`} seen since the previous such event. Any other `stop_det` while idle empties the buffer and programs nothing.
- R5: A `byte_stb` with `wp_on` high stores nothing. A STOP that would commit an empty buffer starts no program cycle.
- R6: In a program cycle, `mem_we` pulses once for each stored position, in ascending position order, one position per clock, starting in the first busy cycle. `mem_addr` = {row, position} and `mem_wdata` is the stored byte. `mem_we` is never high while `busy` is low.
- R7: `busy` rises in the cycle after the committing STOP and stays high for exactly `PROG_CYCLES` cycles.
- R8: While `busy` is high, `addr_load`, `byte_stb`, `ack_done`, `bit_tick`, `stop_det` and `abort` have no effect: no extra cycle follows and the row being written does not change.
- R9: `abort` while idle empties the buffer and cancels a pending acknowledge, so a following ACK-then-STOP programs nothing.
- R10: The buffer is emptied when a program cycle ends, so an ACK-then-STOP with no new bytes starts no second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load the start address of a write command |
| addr_in | input | 13 | Byte address presented with `addr_load` |
| byte_stb | input | 1 | A data byte has been received |
| byte_in | input | 8 | Data byte presented with `byte_stb` |
| wp_on | input | 1 | Write protect; refuses bytes strobed while high |
| ack_done | input | 1 | An acknowledge slot has just completed |
| bit_tick | input | 1 | A new bus bit slot has begun |
| stop_det | input | 1 | STOP condition detected (one-cycle pulse) |
| abort | input | 1 | Drop the current command |
| busy | output | 1 | Program cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions rely on the bus engine giving every event input as a single-cycle pulse in the system clock domain, and on reset being held low from time zero. They also rely on `PROG_CYCLES` being larger than the row, so that the copy always ends before the hold phase. The stimulus drives each pulse for exactly one clock with an idle clock after it. It waits out each whole program cycle before the next command, except in the test that deliberately pushes traffic into a busy cycle. Expected writes come from a separate model of the row buffer: a position map filled by the same byte sequence, then read in ascending order.

// File: rtl/page_prog_pkg.sv
package page_prog_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_COPY = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;

endpackage

// File: rtl/pp_page_latch.sv
module pp_page_latch #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busy,
  input  logic                     addr_load,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic                     byte_stb,
  input  logic [DATA_W-1:0]        byte_in,
  input  logic                     wp_on,
  input  logic                     clear,
  input  logic [PAGE_W-1:0]        rd_idx,
  output logic [ADDR_W-PAGE_W-1:0] row,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     any_valid
);
  localparam int ROW_W = ADDR_W - PAGE_W;
  localparam int SLOTS = 1 << PAGE_W;

  logic [ROW_W-1:0]  row_q, row_d;
  logic [PAGE_W-1:0] ptr_q, ptr_d;
  logic [SLOTS-1:0]  mask_q, mask_d;
  logic [SLOTS-1:0]  slot_we;
  logic [DATA_W-1:0] data_q [SLOTS];
  logic              take_byte;

  // clear (abort / discard / end of cycle) outranks a new address, which outranks a byte
  assign take_byte = !busy && !clear && !addr_load && byte_stb && !wp_on;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      assign slot_we[g] = take_byte && (ptr_q == PAGE_W'(g));
      always_ff @(posedge clk) begin
        if (slot_we[g]) data_q[g] <= byte_in;
      end
    end
  endgenerate

  always_comb begin
    row_d  = row_q;
    ptr_d  = ptr_q;
    mask_d = mask_q;
    if (clear) begin
      mask_d = '0;
    end else if (!busy && addr_load) begin
      row_d  = addr_in[ADDR_W-1:PAGE_W];
      ptr_d  = addr_in[PAGE_W-1:0];
      mask_d = '0;
    end else if (take_byte) begin
      mask_d = mask_q | slot_we;
      ptr_d  = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      ptr_q  <= '0;
      mask_q <= '0;
    end else begin
      row_q  <= row_d;
      ptr_q  <= ptr_d;
      mask_q <= mask_d;
    end
  end

  assign row       = row_q;
  assign rd_valid  = mask_q[rd_idx];
  assign rd_data   = data_q[rd_idx];
  assign any_valid = |mask_q;

endmodule

// File: rtl/pp_slot_arm.sv
module pp_slot_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic ack_done,
  input  logic bit_tick,
  input  logic byte_stb,
  input  logic addr_load,
  input  logic abort,
  input  logic stop_det,
  input  logic any_valid,
  output logic commit,
  output logic discard
);
  logic armed_q, armed_d;
  logic other_evt;

  assign other_evt = bit_tick | byte_stb | addr_load | abort | stop_det;

  always_comb begin
    armed_d = armed_q;
    if (busy)          armed_d = 1'b0;
    else if (ack_done) armed_d = 1'b1;
    else if (other_evt) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign commit  = !busy && stop_det && armed_q && any_valid;
  assign discard = !busy && (abort || (stop_det && !commit));

endmodule

// File: rtl/pp_sequencer.sv
module pp_sequencer
  import page_prog_pkg::*;
#(
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  output logic              busy,
  output logic              copying,
  output logic [PAGE_W-1:0] idx,
  output logic              done
);
  localparam int CNT_W = $clog2(PROG_CYCLES);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [PAGE_W-1:0] IDX_LAST = '1;

  seq_state_e        state_q, state_d;
  logic [PAGE_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (commit) begin
          state_d = SEQ_COPY;
          idx_d   = '0;
          cnt_d   = '0;
        end
      end
      SEQ_COPY: begin
        idx_d = idx_q + 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (idx_q == IDX_LAST) state_d = SEQ_HOLD;
      end
      SEQ_HOLD: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy    = (state_q != SEQ_IDLE);
  assign copying = (state_q == SEQ_COPY);
  assign idx     = idx_q;
  assign done    = (state_q == SEQ_HOLD) && (cnt_q == CNT_LAST);

endmodule

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 5,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              wp_on,
  input  logic              ack_done,
  input  logic              bit_tick,
  input  logic              stop_det,
  input  logic              abort,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic              commit, discard, done, copying, any_valid, rd_valid;
  logic [PAGE_W-1:0] idx;
  logic [ROW_W-1:0]  row;
  logic [DATA_W-1:0] rd_data;

  pp_slot_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .ack_done  (ack_done),
    .bit_tick  (bit_tick),
    .byte_stb  (byte_stb),
    .addr_load (addr_load),
    .abort     (abort),
    .stop_det  (stop_det),
    .any_valid (any_valid),
    .commit    (commit),
    .discard   (discard)
  );

  pp_page_latch #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .addr_load (addr_load),
    .addr_in   (addr_in),
    .byte_stb  (byte_stb),
    .byte_in   (byte_in),
    .wp_on     (wp_on),
    .clear     (discard | done),
    .rd_idx    (idx),
    .row       (row),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .any_valid (any_valid)
  );

  pp_sequencer #(
    .PAGE_W      (PAGE_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .busy    (busy),
    .copying (copying),
    .idx     (idx),
    .done    (done)
  );

  assign mem_we    = copying && rd_valid;
  assign mem_addr  = {row, idx};
  assign mem_wdata = rd_data;

endmodule

// File: rtl/page_prog_ctrl_chk.sv
module page_prog_ctrl_chk #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 500000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_det,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_we_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[PAGE_W-1:0] > $past(mem_addr[PAGE_W-1:0])));

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == PROG_CYCLES));

  assert_start_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  assert_row_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));

endmodule

bind page_prog_ctrl page_prog_ctrl_chk #(
  .ADDR_W      (ADDR_W),
  .PAGE_W      (PAGE_W),
  .PROG_CYCLES (PROG_CYCLES)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .stop_det (stop_det),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/page_prog_ctrl_tb_top.sv
module page_prog_ctrl_tb_top;
  localparam int PROG = 48;

  typedef struct packed {
    logic [12:0] addr;
    logic [5:0]  n;
    logic        wp;
    logic [1:0]  mode;   // 0 stop after ack, 1 stop after a bit slot, 2 abort first
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{13'h0000, 6'd1,  1'b0, 2'd0, 8'h3C},  // R2 single byte
    '{13'h1234, 6'd5,  1'b0, 2'd0, 8'hA1},  // R2 mid-row start
    '{13'h1FFE, 6'd4,  1'b0, 2'd0, 8'h50},  // R3 wrap in last row
    '{13'h0040, 6'd40, 1'b0, 2'd0, 8'h07},  // R3 overwrite after wrap
    '{13'h0100, 6'd3,  1'b0, 2'd1, 8'h90},  // R4 late stop
    '{13'h0100, 6'd3,  1'b1, 2'd0, 8'h90},  // R5 protected bytes
    '{13'h0200, 6'd3,  1'b0, 2'd2, 8'h66},  // R9 abort
    '{13'h0333, 6'd0,  1'b0, 2'd0, 8'h00},  // R5 empty buffer
    '{13'h07E0, 6'd32, 1'b0, 2'd0, 8'hC3}   // R6 full row
  };

  logic        clk, rst_n;
  logic        addr_load, byte_stb, wp_on, ack_done, bit_tick, stop_det, abort;
  logic [12:0] addr_in;
  logic [7:0]  byte_in;
  logic        busy, mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0;
  int fails  = 0;

  logic [12:0] cap_a [512];
  logic [7:0]  cap_d [512];
  int          cap_n = 0;
  int          busy_total = 0;

  logic [7:0]  exp_d [32];
  logic        exp_m [32];

  page_prog_ctrl #(.PROG_CYCLES(PROG)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_load (addr_load),
    .addr_in   (addr_in),
    .byte_stb  (byte_stb),
    .byte_in   (byte_in),
    .wp_on     (wp_on),
    .ack_done  (ack_done),
    .bit_tick  (bit_tick),
    .stop_det  (stop_det),
    .abort     (abort),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && busy) busy_total = busy_total + 1;
    if (rst_n && mem_we && cap_n < 512) begin
      cap_a[cap_n] = mem_addr;
      cap_d[cap_n] = mem_wdata;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic p_addr(input logic [12:0] a);
    @(negedge clk); addr_load = 1'b1; addr_in = a;
    @(negedge clk); addr_load = 1'b0;
  endtask
  task automatic p_byte(input logic [7:0] d, input logic w);
    @(negedge clk); byte_stb = 1'b1; byte_in = d; wp_on = w;
    @(negedge clk); byte_stb = 1'b0; wp_on = 1'b0;
  endtask
  task automatic p_ack();
    @(negedge clk); ack_done = 1'b1;
    @(negedge clk); ack_done = 1'b0;
  endtask
  task automatic p_tick();
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
  endtask
  task automatic p_stop();
    @(negedge clk); stop_det = 1'b1;
    @(negedge clk); stop_det = 1'b0;
  endtask
  task automatic p_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  // compare captured writes from base against the model buffer, ascending positions
  task automatic cmp_writes(input int base, input logic [7:0] row, input string tag);
    int k = 0;
    for (int p = 0; p < 32; p++) begin
      if (exp_m[p]) begin
        chk((cap_a[base+k] == {row, p[4:0]}) && (cap_d[base+k] == exp_d[p]), tag,
            int'({cap_a[base+k], cap_d[base+k]}), int'({row, p[4:0], exp_d[p]}));
        k++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    addr_load = 1'b0; byte_stb = 1'b0; wp_on = 1'b0; ack_done = 1'b0;
    bit_tick = 1'b0; stop_det = 1'b0; abort = 1'b0;
    addr_in = '0; byte_in = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(mem_we == 1'b0, "R1 we in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && mem_we == 1'b0, "R1 after release", int'({busy, mem_we}), 0);

    // vector walk
    for (int v = 0; v < 9; v++) begin
      automatic vec_t c = VECS[v];
      automatic int base_w = cap_n;
      automatic int base_b = busy_total;
      automatic int nm = 0;
      automatic bit go;
      automatic string tag;
      for (int p = 0; p < 32; p++) begin exp_m[p] = 1'b0; exp_d[p] = '0; end
      p_addr(c.addr);
      p_ack();
      for (int i = 0; i < int'(c.n); i++) begin
        automatic logic [7:0] d = c.seed + 8'(i * 7);
        automatic int pos = (int'(c.addr[4:0]) + i) % 32;
        p_tick();
        p_byte(d, c.wp);
        p_ack();
        if (!c.wp) begin exp_m[pos] = 1'b1; exp_d[pos] = d; end
      end
      if (c.mode == 2'd1) begin p_tick(); p_stop(); end
      else if (c.mode == 2'd2) begin p_abort(); p_ack(); p_stop(); end
      else p_stop();
      repeat (PROG + 20) @(negedge clk);
      for (int p = 0; p < 32; p++) nm += int'(exp_m[p]);
      go = (c.mode == 2'd0) && (nm > 0);
      tag = (c.mode == 2'd1) ? "R4" : (c.mode == 2'd2) ? "R9" : c.wp ? "R5" : (nm == 0) ? "R5" : "R7";
      chk((busy_total - base_b) == (go ? PROG : 0), tag, busy_total - base_b, go ? PROG : 0);
      chk((cap_n - base_w) == (go ? nm : 0), "R6 write count", cap_n - base_w, go ? nm : 0);
      if (go && (cap_n - base_w) == nm) cmp_writes(base_w, c.addr[12:5], "R2/R3 write content");
    end

    // R8: traffic during a busy cycle is disregarded
    begin
      automatic int base_w = cap_n;
      automatic int base_b = busy_total;
      for (int p = 0; p < 32; p++) begin exp_m[p] = 1'b0; exp_d[p] = '0; end
      exp_m[5] = 1'b1; exp_d[5] = 8'h11;
      exp_m[6] = 1'b1; exp_d[6] = 8'h22;
      p_addr(13'h0A05); p_ack();
      p_byte(8'h11, 1'b0); p_ack();
      p_byte(8'h22, 1'b0); p_ack();
      p_stop();
      chk(busy == 1'b1, "R7 busy after stop", int'(busy), 1);
      p_addr(13'h1F00); p_ack();
      p_byte(8'h99, 1'b0); p_ack();
      p_stop(); p_abort();
      repeat (PROG + 20) @(negedge clk);
      chk((busy_total - base_b) == PROG, "R8 single cycle", busy_total - base_b, PROG);
      chk((cap_n - base_w) == 2, "R8 write count", cap_n - base_w, 2);
      if ((cap_n - base_w) == 2) cmp_writes(base_w, 8'h50, "R8 row kept");
      chk(busy == 1'b0, "R7 busy ends", int'(busy), 0);

      // R10: buffer emptied after the cycle
      base_b = busy_total;
      p_ack(); p_stop();
      repeat (10) @(negedge clk);
      chk((busy_total - base_b) == 0, "R10 no second cycle", busy_total - base_b, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule